// File: doc/BRIEF.md
# Boot Configuration Loader

This block runs the offline phase of a configurable processing engine. While the `offline` input is high it fills an internal configuration memory byte by byte, through a write port at its edge. In automatic mode it walks a 12-bit address through an external boot memory. It reads one byte per period of a read strobe, which it makes by dividing the master clock at a rate picked by three speed-select pins. In manual mode a host hands over bytes one at a time with a request/acknowledge handshake instead.

Once the configured number of bytes has been stored, `end_offline` rises, and the system may then lower `offline` to enter the on-line phase. A drop of `offline` before that point raises a sticky active-low error flag.

Every change of `offline`, and every cycle with `preset_n` low, puts the block into an internal reset hold. The hold lasts through the next three clock cycles. It rewinds the address, stops the strobe and clears completion. The meaning of the bytes loaded is not interpreted here.

Top module: `cfgl_boot_loader`

## Requirements
- R1: While `offline` is low, no write takes place, `ext_rd_strobe` stays low and `rd_req` pulses raise neither `wr_en` nor `ready`.
- R2: In automatic mode (`auto_mode`=1), one byte is captured in the last clock cycle of each strobe period. It is written with `wr_addr` equal to `mem_addr`, which starts at 0 and rises by 1 per byte.
- R3: The strobe period in clock cycles is 32 for `speed_sel`=3'b000, 16 for 3'b001 and 32 for every other code. The strobe is high for the first half of each period.
- R4: In manual mode (`auto_mode`=0), a rising edge of `rd_req` writes `din` in that same cycle at the current address. `ready` is high from the next cycle until the cycle after `rd_req` falls.
- R5: `end_offline` rises in the cycle after the write of byte LOAD_LEN-1 and stays high while `offline` and `preset_n` are stable. After that, no writes occur and the strobe stays low.
- R6: A change of `offline` sampled at a clock edge holds the block for that cycle and the next three. It returns `mem_addr` to 0, clears `end_offline` and `ready`, and blocks writes and the strobe. In automatic mode the strobe first rises in the fourth cycle after the edge.
- R7: A cycle with `preset_n` low starts the same three-cycle hold counted from its last low cycle, and it also returns `err_n` to 1.
- R8: If `offline` falls while `end_offline` is low, `err_n` goes low in the next cycle and stays low until a preset. A fall after completion leaves `err_n` high.
- R9: `mem_addr` is a 12-bit output that carries the address of the byte being fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| preset_n | input | 1 | Active-low preset, starts the reset hold |
| offline | input | 1 | High enables the download phase |
| auto_mode | input | 1 | 1: automatic fetch, 0: manual handshake |
| speed_sel | input | 3 | Strobe divide select |
| rd_req | input | 1 | Manual byte request, active high |
| din | input | 8 | Byte from boot memory or host |
| ready | output | 1 | Manual byte acknowledge |
| ext_rd_strobe | output | 1 | Divided read strobe to boot memory |
| mem_addr | output | 12 | Boot memory address |
| wr_en | output | 1 | Configuration memory write enable |
| wr_addr | output | 12 | Configuration memory write address |
| wr_data | output | 8 | Configuration memory write data |
| end_offline | output | 1 | All bytes stored |
| err_n | output | 1 | Active-low early-exit error |

## Verification
The bench runs complete automatic downloads at speed codes 000, 001 and 101. These separate the two divide ratios from the fallback. An address-derived memory pattern catches any wrong or skipped address, and the spacing between writes shows an off-by-one in the divider.

Manual transfers with distinct bytes test the edge detection and the timing of `ready`. A preset in the middle of a download and a drop of `offline` in the middle of a download test the length of the hold and the error path. `rd_req` pulses with `offline` low test that requests are ignored there.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int SLOW_DIV = 32;
    localparam int FAST_DIV = 16;
    localparam int DIV_W    = $clog2(SLOW_DIV);

    typedef enum logic [SEL_W-1:0] {
        SPD_SLOW = 3'b000,
        SPD_FAST = 3'b001
    } speed_code_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_write_t;

    // Strobe period for a speed code; unlisted codes use the slow rate.
    function automatic logic [DIV_W:0] div_ratio(input logic [SEL_W-1:0] sel);
        if (sel == SPD_FAST) return (DIV_W+1)'(FAST_DIV);
        return (DIV_W+1)'(SLOW_DIV);
    endfunction

endpackage

// File: rtl/cfgl_hold_ctrl.sv
module cfgl_hold_ctrl #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic preset_n,
    input  logic offline,
    output logic hold,
    output logic off_fall
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic          offline_q;
    logic [HW-1:0] hold_cnt;
    logic          trig;

    assign trig     = !preset_n || (offline != offline_q);
    assign hold     = trig || (hold_cnt != '0);
    assign off_fall = offline_q && !offline;

    always_ff @(posedge clk) begin
        offline_q <= offline;
        if (trig)
            hold_cnt <= HW'(HOLD_CYC);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    // R6: an offline change keeps the hold on for the following cycles
    assert_offline_hold_R6: assert property (@(posedge clk) disable iff (!preset_n)
        (offline != offline_q) |=> hold ##1 hold ##1 hold);

endmodule

// File: rtl/cfgl_strobe_gen.sv
module cfgl_strobe_gen
    import cfgl_pkg::*;
(
    input  logic             clk,
    input  logic             preset_n,
    input  logic             hold,
    input  logic             run,
    input  logic [SEL_W-1:0] speed_sel,
    output logic             strobe,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   ratio;
    logic             live;

    assign ratio  = div_ratio(speed_sel);
    assign live   = run && !hold;
    assign tick   = live && ({1'b0, div_cnt} >= ratio - 1'b1);
    assign strobe = live && ({1'b0, div_cnt} < (ratio >> 1));

    always_ff @(posedge clk) begin
        if (!live || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // R3: capture happens in the low half of the strobe period
    assert_capture_low_R3: assert property (@(posedge clk) disable iff (!preset_n)
        tick |-> !strobe);

    // R3: the strobe starts high again right after a capture while running
    assert_period_restart_R3: assert property (@(posedge clk) disable iff (!preset_n)
        (tick && run) |=> (strobe || hold || !run));

endmodule

// File: rtl/cfgl_load_seq.sv
module cfgl_load_seq
    import cfgl_pkg::*;
#(
    parameter int LOAD_LEN = 64
) (
    input  logic              clk,
    input  logic              preset_n,
    input  logic              hold,
    input  logic              off_fall,
    input  logic              offline,
    input  logic              auto_mode,
    input  logic              tick,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] din,
    output cfg_write_t        wr,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              ready,
    output logic              err_n
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LOAD_LEN - 1);

    logic rd_q;
    logic man_cap;

    assign man_cap = offline && !auto_mode && !done && !hold && rd_req && !rd_q;

    always_comb begin
        wr.en   = tick || man_cap;
        wr.addr = addr;
        wr.data = din;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_req;
        if (hold) begin
            addr  <= '0;
            done  <= 1'b0;
            ready <= 1'b0;
        end else begin
            if (wr.en) begin
                if (addr == LAST) done <= 1'b1;
                else              addr <= addr + 1'b1;
            end
            if (man_cap)      ready <= 1'b1;
            else if (!rd_req) ready <= 1'b0;
        end
        if (!preset_n)
            err_n <= 1'b1;
        else if (off_fall && !done)
            err_n <= 1'b0;
    end

    // R2: each non-final write advances the address by one
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!preset_n)
        (wr.en && addr != LAST && !hold) |=> (addr == $past(addr) + 1'b1) || hold);

    // R5: completion follows the final write
    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!preset_n)
        (wr.en && addr == LAST && !hold) |=> done || hold);

    // R8: error stays latched until preset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!preset_n)
        !err_n |=> !err_n);

endmodule

// File: rtl/cfgl_boot_loader.sv
module cfgl_boot_loader
    import cfgl_pkg::*;
#(
    parameter int LOAD_LEN = 64,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              preset_n,
    input  logic              offline,
    input  logic              auto_mode,
    input  logic [SEL_W-1:0]  speed_sel,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] din,
    output logic              ready,
    output logic              ext_rd_strobe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              end_offline,
    output logic              err_n
);
    logic       hold, off_fall, run, tick, done;
    cfg_write_t wr;

    assign run = offline && auto_mode && !done;

    cfgl_hold_ctrl #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .preset_n(preset_n), .offline(offline),
        .hold(hold), .off_fall(off_fall)
    );

    cfgl_strobe_gen u_strobe (
        .clk(clk), .preset_n(preset_n), .hold(hold), .run(run),
        .speed_sel(speed_sel), .strobe(ext_rd_strobe), .tick(tick)
    );

    cfgl_load_seq #(.LOAD_LEN(LOAD_LEN)) u_seq (
        .clk(clk), .preset_n(preset_n), .hold(hold), .off_fall(off_fall),
        .offline(offline), .auto_mode(auto_mode), .tick(tick),
        .rd_req(rd_req), .din(din), .wr(wr), .addr(mem_addr),
        .done(done), .ready(ready), .err_n(err_n)
    );

    assign wr_en       = wr.en;
    assign wr_addr     = wr.addr;
    assign wr_data     = wr.data;
    assign end_offline = done;

    // R1: nothing is written in the on-line phase
    assert_quiet_online_R1: assert property (@(posedge clk) disable iff (!preset_n)
        !offline |-> (!wr_en && !ext_rd_strobe));

    // R5: no traffic after completion
    assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!preset_n)
        end_offline |-> (!wr_en && !ext_rd_strobe));

    // R6: the cycle after an offline change is silent and rewound
    assert_change_rewinds_R6: assert property (@(posedge clk) disable iff (!preset_n)
        (offline != $past(offline)) |=> (!wr_en && !end_offline && mem_addr == '0));

endmodule

// File: tb/tb_cfgl_boot_loader.sv
`timescale 1ns/1ps
module tb_cfgl_boot_loader;
    localparam int LEN = 64;

    logic        clk = 1'b0;
    logic        preset_n, offline, auto_mode, rd_req;
    logic [2:0]  speed_sel;
    logic [7:0]  din, man_byte;
    logic        ready, ext_rd_strobe, wr_en, end_offline, err_n;
    logic [11:0] mem_addr, wr_addr;
    logic [7:0]  wr_data;
    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    assign din = auto_mode ? mem_byte(int'(mem_addr)) : man_byte;

    cfgl_boot_loader #(.LOAD_LEN(LEN)) dut (
        .clk(clk), .preset_n(preset_n), .offline(offline), .auto_mode(auto_mode),
        .speed_sel(speed_sel), .rd_req(rd_req), .din(din), .ready(ready),
        .ext_rd_strobe(ext_rd_strobe), .mem_addr(mem_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .end_offline(end_offline), .err_n(err_n)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_preset();
        @(negedge clk);
        preset_n = 1'b0;
        cycle();
        preset_n = 1'b1;
        repeat (4) cycle();
    endtask

    task automatic test_reset();
        check(end_offline == 1'b0, "R7 reset end_offline", int'(end_offline), 0);
        check(err_n == 1'b1, "R7 reset err_n", int'(err_n), 1);
        check(wr_en == 1'b0 && ext_rd_strobe == 1'b0, "R1 reset idle", int'(wr_en), 0);
    endtask

    task automatic test_online_ignore();
        int bad = 0;
        offline = 1'b0; auto_mode = 1'b0;
        repeat (4) cycle();
        for (int i = 0; i < 3; i++) begin
            man_byte = 8'(i + 9);
            rd_req = 1'b1; #1;
            if (wr_en) bad++;
            cycle();
            if (ready || ext_rd_strobe) bad++;
            rd_req = 1'b0;
            cycle();
        end
        check(bad == 0, "R1 requests ignored while online", bad, 0);
    endtask

    task automatic test_auto(input logic [2:0] sel, input int ratio, input string tag);
        int idx = 0, cnt = 0, last = 0, bad_addr = 0, bad_gap = 0, early = 0;
        speed_sel = sel; auto_mode = 1'b1;
        @(negedge clk);
        offline = 1'b1;
        while (!end_offline && idx < 5000) begin
            cycle();
            if (idx < 3 && (ext_rd_strobe || wr_en)) early++;
            if (idx == 3)
                check(ext_rd_strobe == 1'b1, {"R6 strobe after hold ", tag}, int'(ext_rd_strobe), 1);
            if (wr_en) begin
                if (wr_addr != 12'(cnt) || mem_addr != 12'(cnt) || wr_data != mem_byte(cnt)) bad_addr++;
                if (cnt == 0)
                    check(idx == ratio + 2, {"R3 first capture ", tag}, idx, ratio + 2);
                else if (idx - last != ratio) bad_gap++;
                last = idx;
                cnt++;
            end
            idx++;
        end
        check(early == 0, {"R6 quiet during hold ", tag}, early, 0);
        check(bad_addr == 0, {"R2 address/data sequence ", tag}, bad_addr, 0);
        check(bad_gap == 0, {"R3 strobe period ", tag}, bad_gap, 0);
        check(cnt == LEN, {"R5 byte count ", tag}, cnt, LEN);
        check(end_offline == 1'b1, {"R5 end_offline ", tag}, int'(end_offline), 1);
        early = 0;
        repeat (40) begin
            cycle();
            if (wr_en || ext_rd_strobe || !end_offline) early++;
        end
        check(early == 0, {"R5 idle after done ", tag}, early, 0);
        offline = 1'b0;
        cycle();
        check(err_n == 1'b1, {"R8 no error after done ", tag}, int'(err_n), 1);
        check(end_offline == 1'b0 && mem_addr == 12'd0, {"R6 rewind ", tag}, int'(mem_addr), 0);
        repeat (4) cycle();
    endtask

    task automatic test_manual();
        int bad = 0;
        auto_mode = 1'b0; speed_sel = 3'b000;
        @(negedge clk);
        offline = 1'b1;
        repeat (5) cycle();
        for (int i = 0; i < 5; i++) begin
            man_byte = 8'(8'hA0 ^ (i * 17));
            rd_req = 1'b1; #1;
            check(wr_en && wr_addr == 12'(i) && wr_data == man_byte, "R4 manual write", int'(wr_addr), i);
            cycle();
            if (!ready || wr_en || ext_rd_strobe) bad++;
            cycle();
            if (!ready || wr_en) bad++;
            rd_req = 1'b0;
            cycle();
            if (ready) bad++;
        end
        check(bad == 0, "R4 ready timing", bad, 0);
        check(mem_addr == 12'd5, "R9 address after manual bytes", int'(mem_addr), 5);
        offline = 1'b0;
        cycle();
        check(err_n == 1'b0, "R8 early exit error", int'(err_n), 0);
        repeat (10) cycle();
        check(err_n == 1'b0, "R8 error sticky", int'(err_n), 0);
        do_preset();
        check(err_n == 1'b1, "R7 preset clears error", int'(err_n), 1);
    endtask

    task automatic test_preset_mid();
        int guard = 0;
        auto_mode = 1'b1; speed_sel = 3'b001;
        @(negedge clk);
        offline = 1'b1;
        while (mem_addr != 12'd2 && guard < 500) begin cycle(); guard++; end
        check(mem_addr == 12'd2, "R9 address mid download", int'(mem_addr), 2);
        preset_n = 1'b0;
        cycle();
        preset_n = 1'b1;
        check(mem_addr == 12'd0 && !ext_rd_strobe, "R7 preset rewinds", int'(mem_addr), 0);
        cycle();
        check(!ext_rd_strobe, "R7 hold cycle 2", int'(ext_rd_strobe), 0);
        cycle();
        check(!ext_rd_strobe, "R7 hold cycle 3", int'(ext_rd_strobe), 0);
        cycle();
        check(ext_rd_strobe == 1'b1, "R7 strobe resumes", int'(ext_rd_strobe), 1);
        offline = 1'b0;
        cycle();
        check(err_n == 1'b0, "R8 abort auto download", int'(err_n), 0);
        do_preset();
    endtask

    initial begin
        preset_n = 1'b0; offline = 1'b0; auto_mode = 1'b1; rd_req = 1'b0;
        speed_sel = 3'b000; man_byte = 8'h00;
        repeat (3) cycle();
        preset_n = 1'b1;
        repeat (4) cycle();
        test_reset();
        test_online_ignore();
        test_auto(3'b000, 32, "div32");
        test_auto(3'b001, 16, "div16");
        test_auto(3'b101, 32, "fallback");
        test_manual();
        test_preset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1_900_000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule